// File: doc/BRIEF.md
# Operand Bypass and Load-Delay Interlock

This block decides, for a five-stage in-order integer pipeline, where each ALU operand of the instruction in the execute stage comes from, and when the front of the pipeline must pause for one cycle. It looks at the two source register numbers in execute, and compares them with the destination register numbers and write flags held in the two stages downstream. Each operand can take the register-file value, the result held after execute, or the result held after memory access.

A second comparator looks at the instruction in decode and at the instruction in execute. The stall fires when the execute instruction is a load and its destination matches either source of the decode instruction. A forwarded value cannot reach in time for that pair. The block then freezes the program counter and the fetch/decode register, and clears the control bits entering execute. The result is a one-cycle bubble. The next cycle the loaded value is picked up from the memory/writeback stage. The block is purely combinational and sits between the pipeline registers of the host datapath.

Top module: `bypass_interlock`

## Requirements
- R1: An operand select is 2'b10 (take the result after execute) when the after-execute write flag is set, its destination is nonzero, and it equals that operand's source number.
- R2: An operand select is 2'b01 (take the result after memory access) when the after-memory write flag is set, its destination is nonzero, it equals that operand's source number, and R1 does not apply.
- R3: When both downstream stages match an operand, the after-execute stage wins (2'b10). A match from a stage whose write flag is clear never blocks the other stage.
- R4: Register number 0 never causes forwarding and never causes a stall, even when a write flag or the load flag is set.
- R5: An operand select is 2'b00 (register file) when no downstream stage with its write flag set matches. This includes a producer three instructions older, which is no longer in either stage.
- R6: When the execute-stage load flag is set and its nonzero destination equals either decode-stage source, the PC hold, the fetch/decode hold and the execute-control flush outputs are all 1.
- R7: With the execute-stage load flag clear, no stall output is raised whatever the register numbers are.
- R8: The three stall outputs are always equal to each other.
- R9: The two operand selects are decided independently. Each one depends only on its own source number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register number of the instruction in execute |
| ex_src_b | input | 5 | Second source register number of the instruction in execute |
| xm_dst | input | 5 | Destination held in the execute/memory register |
| xm_wen | input | 1 | Register write flag held in the execute/memory register |
| mw_dst | input | 5 | Destination held in the memory/writeback register |
| mw_wen | input | 1 | Register write flag held in the memory/writeback register |
| dc_src_a | input | 5 | First source register number of the instruction in decode |
| dc_src_b | input | 5 | Second source register number of the instruction in decode |
| dx_dst | input | 5 | Destination held in the decode/execute register |
| dx_load | input | 1 | Memory-read flag held in the decode/execute register |
| byp_a | output | 2 | Source select for ALU operand A (00 regfile, 10 after-execute, 01 after-memory) |
| byp_b | output | 2 | Source select for ALU operand B, same encoding |
| pc_hold | output | 1 | Keep the program counter unchanged this cycle |
| fd_hold | output | 1 | Keep the fetch/decode register unchanged this cycle |
| dx_flush | output | 1 | Clear the control bits written into the decode/execute register |

## Verification
Some rules are checked whenever the inputs change. A zero source number never selects a bypass. With no write flag set, both selects fall back to the register file. With the load flag clear, no stall appears. When both stages match, the after-execute stage wins. The three stall outputs always agree. Other behaviour can only be shown by the bench's scenarios. These are the exact select codes, the case where a disabled stage must not mask an enabled one, the independence of the two operands, and the sequence from load, through the bubble cycle, to the after-memory bypass.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_MEMWB   = 2'b01,
        SRC_EXMEM   = 2'b10
    } byp_sel_e;

endpackage

// File: rtl/byp_select.sv
module byp_select
    import bypass_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] xm_dst,
    input  logic          xm_wen,
    input  logic [AW-1:0] mw_dst,
    input  logic          mw_wen,
    output byp_sel_e      sel
);

    localparam logic [AW-1:0] ZERO_REG = '0;

    logic     xm_hit_d;
    logic     mw_hit_d;
    byp_sel_e sel_d;

    always_comb begin
        xm_hit_d = xm_wen && (xm_dst != ZERO_REG) && (xm_dst == src);
        mw_hit_d = mw_wen && (mw_dst != ZERO_REG) && (mw_dst == src);
        // younger producer first
        if (xm_hit_d)      sel_d = SRC_EXMEM;
        else if (mw_hit_d) sel_d = SRC_MEMWB;
        else               sel_d = SRC_REGFILE;
    end

    assign sel = sel_d;

    always_comb begin
        a_r4_zero_src_no_bypass: assert ((src != ZERO_REG) || (sel == SRC_REGFILE))
            else $error("zero source picked a bypass");
        a_r5_no_writer_regfile: assert (xm_wen || mw_wen || (sel == SRC_REGFILE))
            else $error("bypass without any writer");
    end

endmodule

// File: rtl/load_delay_detect.sv
module load_delay_detect #(
    parameter int AW      = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0][AW-1:0] dc_src,
    input  logic [AW-1:0]              dx_dst,
    input  logic                       dx_load,
    output logic                       stall
);

    localparam logic [AW-1:0] ZERO_REG = '0;

    logic stall_d;

    always_comb begin
        stall_d = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (dc_src[i] == dx_dst) stall_d = 1'b1;
        end
        stall_d = stall_d && dx_load && (dx_dst != ZERO_REG);
    end

    assign stall = stall_d;

    always_comb begin
        a_r7_stall_needs_load: assert (dx_load || !stall)
            else $error("stall without a load in execute");
    end

endmodule

// File: rtl/bypass_interlock.sv
module bypass_interlock
    import bypass_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] ex_src_a,
    input  logic [AW-1:0] ex_src_b,
    input  logic [AW-1:0] xm_dst,
    input  logic          xm_wen,
    input  logic [AW-1:0] mw_dst,
    input  logic          mw_wen,
    input  logic [AW-1:0] dc_src_a,
    input  logic [AW-1:0] dc_src_b,
    input  logic [AW-1:0] dx_dst,
    input  logic          dx_load,
    output logic [1:0]    byp_a,
    output logic [1:0]    byp_b,
    output logic          pc_hold,
    output logic          fd_hold,
    output logic          dx_flush
);

    localparam int NUM_OPS = 2;

    logic [NUM_OPS-1:0][AW-1:0] ex_src;
    logic [NUM_OPS-1:0][AW-1:0] dc_src;
    byp_sel_e                   sel [NUM_OPS];
    logic                       stall;

    assign ex_src = {ex_src_b, ex_src_a};
    assign dc_src = {dc_src_b, dc_src_a};

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        byp_select #(.AW(AW)) u_sel (
            .src    (ex_src[g]),
            .xm_dst (xm_dst),
            .xm_wen (xm_wen),
            .mw_dst (mw_dst),
            .mw_wen (mw_wen),
            .sel    (sel[g])
        );
    end

    load_delay_detect #(.AW(AW), .NUM_SRC(NUM_OPS)) u_ld (
        .dc_src  (dc_src),
        .dx_dst  (dx_dst),
        .dx_load (dx_load),
        .stall   (stall)
    );

    assign byp_a    = sel[0];
    assign byp_b    = sel[1];
    assign pc_hold  = stall;
    assign fd_hold  = stall;
    assign dx_flush = stall;

    always_comb begin
        a_r3_exmem_wins_a: assert (!(xm_wen && mw_wen && xm_dst == mw_dst && xm_dst == ex_src_a
                                     && ex_src_a != '0) || byp_a == SRC_EXMEM)
            else $error("priority lost on operand A");
        a_r8_stall_agree: assert ((pc_hold == fd_hold) && (fd_hold == dx_flush))
            else $error("stall outputs disagree");
        a_r4_zero_dst_no_stall: assert ((dx_dst != '0) || !dx_flush)
            else $error("stall on register zero");
    end

endmodule

// File: tb/bypass_interlock_bench.sv
module bypass_interlock_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [4:0] ea, eb, xd; logic xw;
        logic [4:0] md; logic mw;
        logic [4:0] da, db, dd; logic dl;
        logic [1:0] exp_a, exp_b; logic exp_st;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 4'd5}, // R5 idle
        '{5'd3, 5'd1, 5'd3, 1'b1, 5'd0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 2'b10, 2'b00, 1'b0, 4'd1}, // R1 op A
        '{5'd1, 5'd4, 5'd4, 1'b1, 5'd0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 2'b00, 2'b10, 1'b0, 4'd1}, // R1 op B
        '{5'd6, 5'd2, 5'd0, 1'b0, 5'd6, 1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 2'b01, 2'b00, 1'b0, 4'd2}, // R2 op A
        '{5'd2, 5'd7, 5'd0, 1'b0, 5'd7, 1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 2'b00, 2'b01, 1'b0, 4'd2}, // R2 op B
        '{5'd8, 5'd1, 5'd8, 1'b1, 5'd8, 1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 2'b10, 2'b00, 1'b0, 4'd3}, // R3 both match
        '{5'd14,5'd1, 5'd14,1'b0, 5'd14,1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 2'b01, 2'b00, 1'b0, 4'd3}, // R3 disabled xm
        '{5'd9, 5'd10,5'd10,1'b1, 5'd9, 1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 2'b01, 2'b10, 1'b0, 4'd9}, // R9 split
        '{5'd13,5'd13,5'd13,1'b1, 5'd0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 2'b10, 2'b10, 1'b0, 4'd9}, // R9 same src
        '{5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 4'd4}, // R4 x0 fwd
        '{5'd11,5'd3, 5'd11,1'b0, 5'd3, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 4'd5}, // R5 no wen
        '{5'd12,5'd15,5'd16,1'b1, 5'd17,1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 4'd5}, // R5 3-behind
        '{5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd5, 5'd7, 5'd5, 1'b1, 2'b00, 2'b00, 1'b1, 4'd6}, // R6 src A
        '{5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd7, 5'd5, 5'd5, 1'b1, 2'b00, 2'b00, 1'b1, 4'd6}, // R6 src B
        '{5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd5, 5'd5, 5'd5, 1'b0, 2'b00, 2'b00, 1'b0, 4'd7}, // R7 no load
        '{5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 5'd6, 5'd0, 1'b1, 2'b00, 2'b00, 1'b0, 4'd4}, // R4 x0 load
        '{5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd6, 5'd8, 5'd5, 1'b1, 2'b00, 2'b00, 1'b0, 4'd7}  // R7 load no match
    };

    logic       clk = 1'b0;
    logic [4:0] ex_src_a, ex_src_b, xm_dst, mw_dst, dc_src_a, dc_src_b, dx_dst;
    logic       xm_wen, mw_wen, dx_load;
    logic [1:0] byp_a, byp_b;
    logic       pc_hold, fd_hold, dx_flush;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bypass_interlock u_bypass_interlock (
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .xm_dst(xm_dst), .xm_wen(xm_wen),
        .mw_dst(mw_dst), .mw_wen(mw_wen), .dc_src_a(dc_src_a), .dc_src_b(dc_src_b),
        .dx_dst(dx_dst), .dx_load(dx_load), .byp_a(byp_a), .byp_b(byp_b),
        .pc_hold(pc_hold), .fd_hold(fd_hold), .dx_flush(dx_flush)
    );

    task automatic drive(input vec_t v);
        @(negedge clk);
        {ex_src_a, ex_src_b, xm_dst, xm_wen, mw_dst, mw_wen} = {v.ea, v.eb, v.xd, v.xw, v.md, v.mw};
        {dc_src_a, dc_src_b, dx_dst, dx_load} = {v.da, v.db, v.dd, v.dl};
        #1;
    endtask

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic check_vec(input vec_t v, input string req);
        check(req, byp_a, v.exp_a, "byp_a");
        check(req, byp_b, v.exp_b, "byp_b");
        check(req, {1'b0, pc_hold}, {1'b0, v.exp_st}, "pc_hold");
        // R8 every stall output follows the same expectation
        check("R8", {fd_hold, dx_flush}, {v.exp_st, v.exp_st}, "fd_hold,dx_flush");
    endtask

    initial begin
        vec_t v;
        // idle state before any stimulus (R5)
        v = '0;
        drive(v);
        check_vec(v, "R5");

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            check_vec(VECS[i], $sformatf("R%0d", VECS[i].req));
        end

        // load x5 then use x5: cycle with load in execute, user in decode (R6)
        v = '0; v.da = 5'd5; v.db = 5'd7; v.dd = 5'd5; v.dl = 1'b1; v.exp_st = 1'b1;
        drive(v); check_vec(v, "R6");
        // bubble in execute, user still in decode, load in after-execute
        v = '0; v.da = 5'd5; v.db = 5'd7; v.xd = 5'd5; v.xw = 1'b1;
        drive(v); check_vec(v, "R6");
        // user in execute, bubble after execute, load after memory: bypass 01 (R2)
        v = '0; v.ea = 5'd5; v.eb = 5'd7; v.md = 5'd5; v.mw = 1'b1; v.exp_a = 2'b01;
        drive(v); check_vec(v, "R2");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R0 watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule